// File: doc/BRIEF.md
# Trap Level State Stack

This block keeps one saved-context entry per trap nesting level. When a trap is taken, the trap-level counter moves up by one. The entry at the new level records the interrupted program counter, the next program counter, the trap type and a packed state word. On trap return, the block presents the saved fields of the current level as a one-cycle restore pulse, reloads the global-register-set selector from them, and then steps the level down. A selector-based register port reads and writes only the entry at the current level. The four visible-entry outputs always show that entry.

The trap-entry and trap-return strobes, and the register write, are plain single-cycle controls. Every strobe is taken in the cycle it is high and none of them is ever held off, so the block has no back-pressure. When the stack is already at its deepest level, a further trap is refused and an error flag is raised. The two counters are published so that neighbouring logic can bank its registers by them.

Top module: `tls_stack`

## Requirements
- R1: After reset the trap level, the global selector, the error flag and the restore pulse are all 0, and every visible-entry output and the read data are 0.
- R2: A trap-entry strobe taken while the level is below MAX_TL raises the level by one at that clock edge. From the next cycle the visible entry shows the strobe's program counter, next program counter and trap type.
- R3: The saved state word is packed from the most significant end as global selector, condition-code byte, address-space identifier, processor-state field and window pointer. The global selector stored is the value held before the trap.
- R4: Each accepted trap entry raises the global selector by one, and the selector stays at MAX_GL once it is there.
- R5: A trap-entry strobe at level MAX_TL changes neither the level, the selector nor any entry. It sets the error flag, which stays set until reset.
- R6: A trap return at a nonzero level drives the restore pulse high for exactly the next cycle. The restore fields carry those of the saved state word at the level the return was taken at. The level drops by one, and the global selector takes the saved selector field, clamped to MAX_GL.
- R7: A trap return at level 0 is ignored: there is no restore pulse and the level and selector stay unchanged.
- R8: When trap entry and trap return are strobed in the same cycle, the entry is performed and the return is dropped.
- R9: The register selector codes are 0 for program counter, 1 for next program counter, 2 for state word and 3 for trap type. Read data is the selected field of the current-level entry, zero-extended, and it follows the selector combinationally. A write stores the low bits of the write data into that field at the next edge.
- R10: While the level is 0, the read data is 0 and register writes change nothing.
- R11: A register write in the same cycle as an accepted trap entry lands in the entry of the level before the trap. The capture fills the new level, and both results are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_take | input | 1 | Trap-entry strobe |
| trap_type | input | TT_W | Cause of the trap being taken |
| trap_pc | input | PC_W | Interrupted program counter |
| trap_npc | input | PC_W | Interrupted next program counter |
| cur_ccr | input | CCR_W | Current condition-code byte |
| cur_asi | input | ASI_W | Current address-space identifier |
| cur_pstate | input | PST_W | Current processor-state field |
| cur_cwp | input | CWP_W | Current window pointer |
| trap_ret | input | 1 | Trap-return strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Field selector for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Selected field of current entry, zero-extended |
| cur_tl | output | TL_W | Current trap level |
| cur_gl | output | GL_W | Current global-register-set selector |
| err_state | output | 1 | Sticky trap-overflow error |
| rest_valid | output | 1 | One-cycle restore pulse |
| rest_gl | output | GL_W | Restored global selector field |
| rest_ccr | output | CCR_W | Restored condition-code byte |
| rest_asi | output | ASI_W | Restored address-space identifier |
| rest_pstate | output | PST_W | Restored processor-state field |
| rest_cwp | output | CWP_W | Restored window pointer |
| vis_pc | output | PC_W | Saved program counter at current level |
| vis_npc | output | PC_W | Saved next program counter at current level |
| vis_state | output | ST_W | Saved state word at current level |
| vis_tt | output | TT_W | Saved trap type at current level |

## Verification
A register write can fall in the same cycle as a trap entry, and the bench provokes this at level 1. It drives a program-counter write together with a trap strobe. It then checks that the new level shows the trap's program counter, and that after one return the old level shows the written value. The bench also raises entry and return together. It judges the result by the level going up, the absence of a restore pulse, and the new capture being visible.

// File: rtl/tls_pkg.sv
package tls_pkg;

  typedef enum logic [1:0] {
    SEL_PC    = 2'd0,
    SEL_NPC   = 2'd1,
    SEL_STATE = 2'd2,
    SEL_TT    = 2'd3
  } tls_sel_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/tls_level_ctrl.sv
module tls_level_ctrl #(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 2,
  parameter int TL_W   = 3,
  parameter int GL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            ret,
  input  logic [GL_W-1:0] ret_gl,
  output logic [TL_W-1:0] tl,
  output logic [GL_W-1:0] gl,
  output logic            take_ok,
  output logic            ret_ok,
  output logic            err
);

  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);
  localparam logic [GL_W-1:0] GL_TOP = GL_W'(MAX_GL);

  logic            at_top;
  logic            at_zero;
  logic [GL_W-1:0] gl_up;
  logic [GL_W-1:0] gl_back;

  assign at_top  = (tl == TL_TOP);
  assign at_zero = (tl == '0);
  assign take_ok = take && !at_top;
  assign ret_ok  = ret && !take && !at_zero;
  assign gl_up   = (gl == GL_TOP) ? gl : gl + GL_W'(1);
  assign gl_back = (ret_gl > GL_TOP) ? GL_TOP : ret_gl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl  <= '0;
      gl  <= '0;
      err <= 1'b0;
    end else begin
      if (take_ok) begin
        tl <= tl + TL_W'(1);
        gl <= gl_up;
      end else if (ret_ok) begin
        tl <= tl - TL_W'(1);
        gl <= gl_back;
      end
      if (take && at_top) err <= 1'b1;
    end
  end

  assert_tl_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tl != TL_TOP) |=> (tl == $past(tl) + TL_W'(1)));

  assert_gl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gl <= GL_TOP);

  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tl == TL_TOP) |=> ($stable(tl) && $stable(gl) && err));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_ret_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take && tl == '0) |=> (tl == '0 && $stable(gl)));

  assert_take_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ret && tl != TL_TOP) |=> (tl == $past(tl) + TL_W'(1)));

endmodule

// File: rtl/tls_entry_bank.sv
module tls_entry_bank #(
  parameter int DEPTH = 6,
  parameter int W     = 32,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [LVL_W-1:0] cap_lvl,
  input  logic [W-1:0]     cap_data,
  input  logic             sw_en,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic [W-1:0]     sw_data,
  input  logic [LVL_W-1:0] rd_lvl,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] slots [1:DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 1; i <= DEPTH; i++) begin
        if (cap_en && cap_lvl == LVL_W'(i))
          slots[i] <= cap_data;
        else if (sw_en && sw_lvl == LVL_W'(i))
          slots[i] <= sw_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 1; i <= DEPTH; i++)
      if (rd_lvl == LVL_W'(i)) rd_data = slots[i];
  end

  assert_cap_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (cap_lvl != '0));

  assert_no_sw_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> (sw_lvl != '0));

  assert_split_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && sw_en) |-> (cap_lvl != sw_lvl));

endmodule

// File: rtl/tls_restore.sv
module tls_restore #(
  parameter int GL_W  = 2,
  parameter int CCR_W = 8,
  parameter int ASI_W = 8,
  parameter int PST_W = 12,
  parameter int CWP_W = 3,
  parameter int ST_W  = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_ok,
  input  logic [ST_W-1:0]  saved,
  output logic             rest_valid,
  output logic [GL_W-1:0]  rest_gl,
  output logic [CCR_W-1:0] rest_ccr,
  output logic [ASI_W-1:0] rest_asi,
  output logic [PST_W-1:0] rest_pstate,
  output logic [CWP_W-1:0] rest_cwp
);

  localparam int PST_LO = CWP_W;
  localparam int ASI_LO = PST_LO + PST_W;
  localparam int CCR_LO = ASI_LO + ASI_W;
  localparam int GL_LO  = CCR_LO + CCR_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rest_valid  <= 1'b0;
      rest_gl     <= '0;
      rest_ccr    <= '0;
      rest_asi    <= '0;
      rest_pstate <= '0;
      rest_cwp    <= '0;
    end else begin
      rest_valid <= ret_ok;
      if (ret_ok) begin
        rest_gl     <= saved[GL_LO +: GL_W];
        rest_ccr    <= saved[CCR_LO +: CCR_W];
        rest_asi    <= saved[ASI_LO +: ASI_W];
        rest_pstate <= saved[PST_LO +: PST_W];
        rest_cwp    <= saved[CWP_W-1:0];
      end
    end
  end

  assert_restore_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rest_valid |-> $past(ret_ok));

  assert_restore_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (rest_cwp == $past(saved[CWP_W-1:0])));

endmodule

// File: rtl/tls_stack.sv
module tls_stack
  import tls_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 2,
  parameter int PC_W   = 48,
  parameter int TT_W   = 9,
  parameter int CCR_W  = 8,
  parameter int ASI_W  = 8,
  parameter int PST_W  = 12,
  parameter int CWP_W  = 3,
  parameter int DATA_W = 64,
  localparam int TL_W  = cnt_width(MAX_TL),
  localparam int GL_W  = cnt_width(MAX_GL),
  localparam int ST_W  = GL_W + CCR_W + ASI_W + PST_W + CWP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_take,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic [PC_W-1:0]   trap_npc,
  input  logic [CCR_W-1:0]  cur_ccr,
  input  logic [ASI_W-1:0]  cur_asi,
  input  logic [PST_W-1:0]  cur_pstate,
  input  logic [CWP_W-1:0]  cur_cwp,
  input  logic              trap_ret,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TL_W-1:0]   cur_tl,
  output logic [GL_W-1:0]   cur_gl,
  output logic              err_state,
  output logic              rest_valid,
  output logic [GL_W-1:0]   rest_gl,
  output logic [CCR_W-1:0]  rest_ccr,
  output logic [ASI_W-1:0]  rest_asi,
  output logic [PST_W-1:0]  rest_pstate,
  output logic [CWP_W-1:0]  rest_cwp,
  output logic [PC_W-1:0]   vis_pc,
  output logic [PC_W-1:0]   vis_npc,
  output logic [ST_W-1:0]   vis_state,
  output logic [TT_W-1:0]   vis_tt
);

  logic            take_ok;
  logic            ret_ok;
  logic            wr_live;
  logic [TL_W-1:0] cap_lvl;
  logic [ST_W-1:0] cap_state;
  logic [GL_W-1:0] saved_gl;
  tls_sel_e        sel;

  assign sel       = tls_sel_e'(reg_sel);
  assign wr_live   = reg_wr && (cur_tl != '0);
  assign cap_lvl   = cur_tl + TL_W'(1);
  assign cap_state = {cur_gl, cur_ccr, cur_asi, cur_pstate, cur_cwp};
  assign saved_gl  = vis_state[ST_W-1 -: GL_W];

  tls_level_ctrl #(
    .MAX_TL (MAX_TL),
    .MAX_GL (MAX_GL),
    .TL_W   (TL_W),
    .GL_W   (GL_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (trap_take),
    .ret     (trap_ret),
    .ret_gl  (saved_gl),
    .tl      (cur_tl),
    .gl      (cur_gl),
    .take_ok (take_ok),
    .ret_ok  (ret_ok),
    .err     (err_state)
  );

  tls_entry_bank #(.DEPTH(MAX_TL), .W(PC_W), .LVL_W(TL_W)) u_pc_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (take_ok),
    .cap_lvl  (cap_lvl),
    .cap_data (trap_pc),
    .sw_en    (wr_live && sel == SEL_PC),
    .sw_lvl   (cur_tl),
    .sw_data  (reg_wdata[PC_W-1:0]),
    .rd_lvl   (cur_tl),
    .rd_data  (vis_pc)
  );

  tls_entry_bank #(.DEPTH(MAX_TL), .W(PC_W), .LVL_W(TL_W)) u_npc_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (take_ok),
    .cap_lvl  (cap_lvl),
    .cap_data (trap_npc),
    .sw_en    (wr_live && sel == SEL_NPC),
    .sw_lvl   (cur_tl),
    .sw_data  (reg_wdata[PC_W-1:0]),
    .rd_lvl   (cur_tl),
    .rd_data  (vis_npc)
  );

  tls_entry_bank #(.DEPTH(MAX_TL), .W(ST_W), .LVL_W(TL_W)) u_state_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (take_ok),
    .cap_lvl  (cap_lvl),
    .cap_data (cap_state),
    .sw_en    (wr_live && sel == SEL_STATE),
    .sw_lvl   (cur_tl),
    .sw_data  (reg_wdata[ST_W-1:0]),
    .rd_lvl   (cur_tl),
    .rd_data  (vis_state)
  );

  tls_entry_bank #(.DEPTH(MAX_TL), .W(TT_W), .LVL_W(TL_W)) u_tt_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (take_ok),
    .cap_lvl  (cap_lvl),
    .cap_data (trap_type),
    .sw_en    (wr_live && sel == SEL_TT),
    .sw_lvl   (cur_tl),
    .sw_data  (reg_wdata[TT_W-1:0]),
    .rd_lvl   (cur_tl),
    .rd_data  (vis_tt)
  );

  tls_restore #(
    .GL_W  (GL_W),
    .CCR_W (CCR_W),
    .ASI_W (ASI_W),
    .PST_W (PST_W),
    .CWP_W (CWP_W),
    .ST_W  (ST_W)
  ) u_restore (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_ok      (ret_ok),
    .saved       (vis_state),
    .rest_valid  (rest_valid),
    .rest_gl     (rest_gl),
    .rest_ccr    (rest_ccr),
    .rest_asi    (rest_asi),
    .rest_pstate (rest_pstate),
    .rest_cwp    (rest_cwp)
  );

  always_comb begin
    unique case (sel)
      SEL_PC:    reg_rdata = DATA_W'(vis_pc);
      SEL_NPC:   reg_rdata = DATA_W'(vis_npc);
      SEL_STATE: reg_rdata = DATA_W'(vis_state);
      default:   reg_rdata = DATA_W'(vis_tt);
    endcase
  end

  assert_zero_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_tl == '0) |-> (reg_rdata == '0));

  assert_capture_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && cur_tl != TL_W'(MAX_TL)) |=> (vis_pc == $past(trap_pc)));

  assert_capture_gl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && cur_tl != TL_W'(MAX_TL)) |=> (saved_gl == $past(cur_gl)));

endmodule

// File: tb/tb_tls_stack.sv
module tb_tls_stack;

  localparam int PC_W = 48;
  localparam int TT_W = 9;
  localparam int ST_W = 33;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trap_take = 1'b0;
  logic [TT_W-1:0]   trap_type = '0;
  logic [PC_W-1:0]   trap_pc = '0;
  logic [PC_W-1:0]   trap_npc = '0;
  logic [7:0]        cur_ccr = '0;
  logic [7:0]        cur_asi = '0;
  logic [11:0]       cur_pstate = '0;
  logic [2:0]        cur_cwp = '0;
  logic              trap_ret = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic [2:0]        cur_tl;
  logic [1:0]        cur_gl;
  logic              err_state;
  logic              rest_valid;
  logic [1:0]        rest_gl;
  logic [7:0]        rest_ccr;
  logic [7:0]        rest_asi;
  logic [11:0]       rest_pstate;
  logic [2:0]        rest_cwp;
  logic [PC_W-1:0]   vis_pc;
  logic [PC_W-1:0]   vis_npc;
  logic [ST_W-1:0]   vis_state;
  logic [TT_W-1:0]   vis_tt;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tls_stack dut (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_type(trap_type),
    .trap_pc(trap_pc), .trap_npc(trap_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
    .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .trap_ret(trap_ret),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cur_tl(cur_tl), .cur_gl(cur_gl),
    .err_state(err_state), .rest_valid(rest_valid), .rest_gl(rest_gl),
    .rest_ccr(rest_ccr), .rest_asi(rest_asi), .rest_pstate(rest_pstate),
    .rest_cwp(rest_cwp), .vis_pc(vis_pc), .vis_npc(vis_npc),
    .vis_state(vis_state), .vis_tt(vis_tt)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input int k);
    return PC_W'(48'h1000 + k * 16);
  endfunction

  function automatic logic [ST_W-1:0] st_of(input int g, input int k);
    return {2'(g), 8'(8'h10 + k), 8'(8'h80 + k), 12'(12'h100 + k), 3'(k)};
  endfunction

  function automatic int min2(input int v);
    return (v > 2) ? 2 : v;
  endfunction

  // Drive one cycle from a negedge; returns at the next negedge.
  task automatic cyc(input bit tk, input bit rt, input bit wr,
                     input logic [1:0] sel, input logic [63:0] wd, input int k);
    trap_take  = tk;
    trap_ret   = rt;
    reg_wr     = wr;
    reg_sel    = sel;
    reg_wdata  = wd;
    trap_pc    = pc_of(k);
    trap_npc   = pc_of(k) + PC_W'(4);
    trap_type  = TT_W'(9'h40 + k);
    cur_ccr    = 8'(8'h10 + k);
    cur_asi    = 8'(8'h80 + k);
    cur_pstate = 12'(12'h100 + k);
    cur_cwp    = 3'(k);
    @(negedge clk);
    trap_take = 1'b0;
    trap_ret  = 1'b0;
    reg_wr    = 1'b0;
  endtask

  task automatic read_sel(input logic [1:0] sel);
    reg_sel = sel;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_zero_level();
    do_reset();
    chk("R1 tl", 64'(cur_tl), 0);
    chk("R1 gl", 64'(cur_gl), 0);
    chk("R1 err", 64'(err_state), 0);
    chk("R1 rest_valid", 64'(rest_valid), 0);
    chk("R1 vis_pc", 64'(vis_pc), 0);
    chk("R1 vis_state", 64'(vis_state), 0);
    cyc(0, 0, 1, 2'd0, 64'hDEAD_BEEF, 0);
    for (int s = 0; s < 4; s++) begin
      read_sel(2'(s));
      chk("R10 read at level 0", reg_rdata, 0);
    end
    chk("R10 tl after write", 64'(cur_tl), 0);
    cyc(0, 1, 0, 2'd0, 0, 0);
    chk("R7 no restore pulse", 64'(rest_valid), 0);
    chk("R7 tl stays", 64'(cur_tl), 0);
    chk("R7 gl stays", 64'(cur_gl), 0);
  endtask

  task automatic test_fill();
    do_reset();
    for (int k = 1; k <= 6; k++) begin
      cyc(1, 0, 0, 2'd0, 0, k);
      chk("R2 tl", 64'(cur_tl), 64'(k));
      chk("R2 vis_pc", 64'(vis_pc), 64'(pc_of(k)));
      chk("R2 vis_npc", 64'(vis_npc), 64'(pc_of(k) + PC_W'(4)));
      chk("R2 vis_tt", 64'(vis_tt), 64'(9'h40 + k));
      chk("R3 vis_state", 64'(vis_state), 64'(st_of(min2(k - 1), k)));
      chk("R4 gl", 64'(cur_gl), 64'(min2(k)));
    end
    chk("R5 err before", 64'(err_state), 0);
    cyc(1, 0, 0, 2'd0, 0, 7);
    chk("R5 tl held", 64'(cur_tl), 6);
    chk("R5 entry kept", 64'(vis_pc), 64'(pc_of(6)));
    chk("R5 gl held", 64'(cur_gl), 2);
    chk("R5 err set", 64'(err_state), 1);
    @(negedge clk);
    chk("R5 err sticky", 64'(err_state), 1);
  endtask

  task automatic test_return();
    // continues from a full stack
    for (int lv = 6; lv >= 1; lv--) begin
      cyc(0, 1, 0, 2'd0, 0, 0);
      chk("R6 rest_valid", 64'(rest_valid), 1);
      chk("R6 rest_ccr", 64'(rest_ccr), 64'(8'h10 + lv));
      chk("R6 rest_asi", 64'(rest_asi), 64'(8'h80 + lv));
      chk("R6 rest_pstate", 64'(rest_pstate), 64'(12'h100 + lv));
      chk("R6 rest_cwp", 64'(rest_cwp), 64'(lv));
      chk("R6 rest_gl", 64'(rest_gl), 64'(min2(lv - 1)));
      chk("R6 tl down", 64'(cur_tl), 64'(lv - 1));
      chk("R6 gl reload", 64'(cur_gl), 64'(min2(lv - 1)));
    end
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(rest_valid), 0);
    cyc(0, 1, 0, 2'd0, 0, 0);
    chk("R7 return at zero", 64'(rest_valid), 0);
    chk("R7 tl zero", 64'(cur_tl), 0);
  endtask

  task automatic test_access();
    do_reset();
    cyc(1, 0, 0, 2'd0, 0, 1);
    cyc(1, 0, 0, 2'd0, 0, 2);
    cyc(0, 0, 1, 2'd0, 64'hFFFF_1234_5678_9ABC, 0);
    read_sel(2'd0);
    chk("R9 pc readback", reg_rdata, 64'h0000_1234_5678_9ABC);
    cyc(0, 0, 1, 2'd1, 64'h42, 0);
    read_sel(2'd1);
    chk("R9 npc readback", reg_rdata, 64'h42);
    cyc(0, 0, 1, 2'd3, 64'hFFFF, 0);
    read_sel(2'd3);
    chk("R9 tt truncated", reg_rdata, 64'h1FF);
    cyc(0, 0, 1, 2'd2, 64'hFFFF_FFF1_8000_0005, 0);
    read_sel(2'd2);
    chk("R9 state truncated", reg_rdata, 64'h1_8000_0005);
    read_sel(2'd0);
    chk("R9 pc untouched", reg_rdata, 64'h0000_1234_5678_9ABC);
    cyc(0, 1, 0, 2'd0, 0, 0);
    chk("R6 rest_gl raw", 64'(rest_gl), 3);
    chk("R6 gl clamped", 64'(cur_gl), 2);
    chk("R6 rest_cwp written", 64'(rest_cwp), 5);
    chk("R9 lower level intact", 64'(vis_pc), 64'(pc_of(1)));
  endtask

  task automatic test_collide();
    do_reset();
    cyc(1, 0, 0, 2'd0, 0, 1);
    cyc(1, 0, 1, 2'd0, 64'hABCD, 2);
    chk("R11 tl", 64'(cur_tl), 2);
    chk("R11 capture kept", 64'(vis_pc), 64'(pc_of(2)));
    cyc(0, 1, 0, 2'd0, 0, 0);
    chk("R11 write kept", 64'(vis_pc), 64'hABCD);
    cyc(1, 1, 0, 2'd0, 0, 3);
    chk("R8 tl up", 64'(cur_tl), 2);
    chk("R8 no restore", 64'(rest_valid), 0);
    chk("R8 capture", 64'(vis_pc), 64'(pc_of(3)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_zero_level();
    test_fill();
    test_return();
    test_access();
    test_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule